// File: doc/BRIEF.md
# Serial Configuration Loader

This block programs a target device through a bit-serial slave configuration port. A host supplies a start strobe with the number of bitstream bytes and then streams those bytes over a valid/ready handshake. The block runs the reset handshake with the target. It pulls the program line low until the target answers by driving its init line active. It then releases program and waits for init to be released again. After that it shifts every byte out on a data line against a divided configuration clock.

Before each byte it checks the target for a load error, which shows as init active while done is still low. After the last byte it holds the data line high and keeps clocking until the target raises done. Each wait is bounded by a timeout counted in system clocks. The result is a single-cycle success or fail pulse with a fail reason code, after which the block returns to idle. The init and done inputs pass through two-flop synchronizers. An error that the target signals during a byte must therefore reach the synchronized input by the end of that byte's last high half-period to be seen before the next byte.

Top module: `fpga_serial_loader`

## Requirements
- R1: A start taken in idle drives `prog_oe` high on the next cycle and holds it until the synchronized init line reads active (low); if that takes `WAIT_CYCLES` cycles the load ends in fail with `fail_code` 1.
- R2: Once init is active, `prog_oe` drops and the block waits for init to return high; if it stays low for `WAIT_CYCLES` cycles the load ends in fail with `fail_code` 2.
- R3: Each byte leaves on `cfg_dout` most significant bit first, one bit per `cfg_clk` period and eight periods per byte. The data line only changes while `cfg_clk` is low and is stable at every rising edge.
- R4: `cfg_clk` spends `HALF_DIV` system clocks low and `HALF_DIV` high, so rising edges within a byte are `2*HALF_DIV` cycles apart.
- R5: Before every byte, and before the final done phase, init active with done low ends the load at once in fail with `fail_code` 3. No further byte is taken and no further clock edge is issued.
- R6: After the last byte `cfg_dout` is 1 at every rising `cfg_clk` edge, and clocking continues until done reads high, which ends the load with a `done_ok` pulse.
- R7: If done stays low for `WAIT_CYCLES` cycles of the final phase, the load ends in fail with `fail_code` 4.
- R8: `done_ok` and `done_fail` are never high together, each pulse lasts one cycle, and a start outside idle, including during that pulse, is ignored.
- R9: Exactly `byte_count` bytes are accepted from the stream (`s_valid` and `s_ready` both high at a clock edge). A count of zero goes straight to the done phase without taking any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken in idle only) |
| byte_count | input | CNT_W | Number of bytes in the load, captured at start |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Bitstream byte available |
| s_ready | output | 1 | Block takes the byte at this edge |
| prog_oe | output | 1 | Drive the target program line low |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_dout | output | 1 | Serial configuration data |
| init_n | input | 1 | Target init line, low = active |
| done_in | input | 1 | Target done line, high = configured |
| done_ok | output | 1 | One-cycle pulse: load succeeded |
| done_fail | output | 1 | One-cycle pulse: load failed |
| fail_code | output | 3 | Fail reason (1..4), cleared at start |

## Verification
The completion pulse and a new start strobe can share a cycle. The bench drives start in the very cycle `done_ok` is seen and then judges that `prog_oe` and `s_ready` stay low, so no second load begins. A second overlap is a target error that arrives as the last bit of a byte is clocked. The target model pulls init low right after sampling the eighth bit of the first byte, and the bench requires a code-3 fail with only that byte received and the remaining bytes left in the source.

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader #(
  parameter int HALF_DIV    = 4,
  parameter int WAIT_CYCLES = 1_000_000,
  parameter int CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             prog_oe,
  output logic             cfg_clk,
  output logic             cfg_dout,
  input  logic             init_n,
  input  logic             done_in,
  output logic             done_ok,
  output logic             done_fail,
  output logic [2:0]       fail_code
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TMR_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WAIT_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_REL, ST_NEXT, ST_SHIFT, ST_TAIL, ST_END
  } st_t;

  st_t              st;
  logic [1:0]       init_sy, done_sy;
  logic [CNT_W-1:0] left;
  logic [7:0]       sh;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] div;
  logic [TMR_W-1:0] tmr;
  logic             ck, ok_q;

  wire init_act = ~init_sy[1];
  wire done_hi  = done_sy[1];
  wire crc_err  = init_act & ~done_hi;
  wire half_end = (div == DIV_LAST);
  wire tmr_exp  = (tmr == TMR_LAST);

  assign s_ready   = (st == ST_NEXT) && !crc_err && (left != '0);
  assign prog_oe   = (st == ST_PROG);
  assign cfg_clk   = ck;
  assign cfg_dout  = (st == ST_TAIL) | sh[7];
  assign done_ok   = (st == ST_END) & ok_q;
  assign done_fail = (st == ST_END) & ~ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_sy <= 2'b11;
      done_sy <= 2'b00;
    end else begin
      init_sy <= {init_sy[0], init_n};
      done_sy <= {done_sy[0], done_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      left      <= '0;
      sh        <= '0;
      bitn      <= '0;
      div       <= '0;
      tmr       <= '0;
      ck        <= 1'b0;
      ok_q      <= 1'b0;
      fail_code <= '0;
    end else begin
      tmr <= tmr + 1'b1;
      div <= half_end ? '0 : div + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          st        <= ST_PROG;
          left      <= byte_count;
          fail_code <= '0;
          tmr       <= '0;
        end
        ST_PROG: if (init_act) begin
          st  <= ST_REL;
          tmr <= '0;
        end else if (tmr_exp) begin
          st <= ST_END; ok_q <= 1'b0; fail_code <= 3'd1;
        end
        ST_REL: if (!init_act) begin
          st <= ST_NEXT;
        end else if (tmr_exp) begin
          st <= ST_END; ok_q <= 1'b0; fail_code <= 3'd2;
        end
        ST_NEXT: if (crc_err) begin
          st <= ST_END; ok_q <= 1'b0; fail_code <= 3'd3;
        end else if (left == '0) begin
          st  <= ST_TAIL;
          tmr <= '0;
          div <= '0;
          ck  <= 1'b0;
        end else if (s_valid) begin
          st   <= ST_SHIFT;
          sh   <= s_data;
          bitn <= '0;
          div  <= '0;
          ck   <= 1'b0;
        end
        ST_SHIFT: if (half_end) begin
          ck <= ~ck;
          if (ck) begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              st   <= ST_NEXT;
              left <= left - 1'b1;
            end
          end
        end
        ST_TAIL: if (done_hi) begin
          st <= ST_END; ok_q <= 1'b1; ck <= 1'b0;
        end else if (tmr_exp) begin
          st <= ST_END; ok_q <= 1'b0; fail_code <= 3'd4; ck <= 1'b0;
        end else if (half_end) begin
          ck <= ~ck;
        end
        ST_END: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_oe) |-> $past(start));

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_dout));

  // R6
  ok_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> $past(done_hi));

  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_fail}));

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fail) |=> !(done_ok || done_fail));

  // R9
  take_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (cfg_clk == 1'b0) && !s_ready);

endmodule

// File: tb/sim_fpga_serial_loader.sv
module sim_fpga_serial_loader;
  localparam int HD = 4;
  localparam int WT = 300;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0;
  logic [CW-1:0] nbytes = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0;
  logic init_n = 1'b1, done_pin = 1'b0;
  wire s_ready, prog_oe, cfg_clk, cfg_dout, done_ok, done_fail;
  wire [2:0] fail_code;

  fpga_serial_loader #(.HALF_DIV(HD), .WAIT_CYCLES(WT), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(nbytes),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .prog_oe(prog_oe), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout),
    .init_n(init_n), .done_in(done_pin),
    .done_ok(done_ok), .done_fail(done_fail), .fail_code(fail_code));

  int checks = 0, errs = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] src_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // target model
  bit m_no_low = 0, m_stuck_low = 0, m_no_done = 0;
  int crc_at = -1, tail_need = 6, load_n = 0;
  int pcnt = 0, rcnt = 0, rx_bits = 0, rx_bytes = 0, tail_cnt = 0, last_rise = -1;
  bit prev_ck = 0, was_prog = 0;
  logic [7:0] rx_sh = '0;

  always @(negedge clk) begin
    if (prog_oe) begin
      was_prog = 1;
      pcnt++;
      if (pcnt == 5 && !m_no_low) init_n = 1'b0;
    end else if (was_prog) begin
      rcnt++;
      if (rcnt == 8 && !m_stuck_low) begin
        init_n = 1'b1;
        was_prog = 0;
      end
    end
    if (cfg_clk && !prev_ck) begin
      if (rx_bytes < load_n) begin
        if (rx_bits % 8 != 0) chk(cyc - last_rise == 2*HD, "R4", cyc - last_rise, 2*HD);
        rx_sh = {rx_sh[6:0], cfg_dout};
        rx_bits++;
        if (rx_bits % 8 == 0) begin
          rx_bytes++;
          if (exp_q.size() == 0) chk(0, "R9", rx_sh, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx_sh == e, "R3", rx_sh, e);
          end
          if (rx_bytes == crc_at) init_n = 1'b0;
        end
      end else begin
        chk(cfg_dout == 1'b1, "R6", cfg_dout, 1);
        tail_cnt++;
        if (tail_cnt == tail_need && !m_no_done) done_pin = 1'b1;
      end
      last_rise = cyc;
    end
    prev_ck = cfg_clk;
  end

  // byte source
  bit hs = 0;
  always @(negedge clk) begin
    if (hs && src_q.size() > 0) void'(src_q.pop_front());
    s_valid = (src_q.size() > 0);
    s_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    hs = s_valid && s_ready;
  end

  bit got_ok;
  int got_code;

  task automatic run_load(input logic [7:0] data[$], input int cnt, input bit strike_end);
    @(posedge clk); #1;
    init_n = 1'b1; done_pin = 1'b0; pcnt = 0; rcnt = 0; was_prog = 0;
    rx_bits = 0; rx_bytes = 0; tail_cnt = 0; last_rise = -1;
    load_n = cnt;
    exp_q.delete();
    for (int i = 0; i < data.size(); i++) begin
      if (i < cnt) exp_q.push_back(data[i]);
      src_q.push_back(data[i]);
    end
    repeat (4) @(posedge clk);
    #1 start = 1'b1; nbytes = CW'(cnt);
    @(posedge clk); #1 start = 1'b0;
    chk(prog_oe == 1'b1, "R1", prog_oe, 1);
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (done_ok || done_fail) break;
    end
    got_ok = done_ok;
    got_code = fail_code;
    if (strike_end) start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(!done_ok && !done_fail, "R8", done_ok | done_fail, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!prog_oe && !s_ready && !done_ok && !done_fail && !cfg_clk, "R8", prog_oe, 0);
    rst_n = 1'b1;

    // normal load, start coinciding with the completion pulse
    run_load('{8'hA5, 8'h5A, 8'h80, 8'h01, 8'hEE}, 4, 1);
    chk(got_ok, "R6", got_ok, 1);
    chk(rx_bytes == 4 && exp_q.size() == 0, "R3", rx_bytes, 4);
    chk(src_q.size() == 1, "R9", src_q.size(), 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!prog_oe && !s_ready, "R8", prog_oe, 0);
    end
    @(posedge clk); #1 src_q.delete();

    // start while busy is ignored
    fork
      begin
        repeat (120) @(posedge clk);
        #1 start = 1'b1; nbytes = CW'(1);
        @(posedge clk); #1 start = 1'b0;
      end
    join_none
    run_load('{8'h00, 8'hFF, 8'h3C}, 3, 0);
    chk(got_ok && rx_bytes == 3, "R8", rx_bytes, 3);
    chk(src_q.size() == 0, "R9", src_q.size(), 0);

    // zero byte count
    run_load('{8'h77}, 0, 0);
    chk(got_ok, "R9", got_ok, 1);
    chk(src_q.size() == 1 && rx_bytes == 0, "R9", src_q.size(), 1);
    chk(tail_cnt >= tail_need, "R6", tail_cnt, tail_need);
    @(posedge clk); #1 src_q.delete();

    // init never asserted
    m_no_low = 1;
    run_load('{8'h11}, 1, 0);
    chk(!got_ok && got_code == 1, "R1", got_code, 1);
    chk(rx_bits == 0, "R1", rx_bits, 0);
    m_no_low = 0;
    @(posedge clk); #1 src_q.delete();

    // init never released
    m_stuck_low = 1;
    run_load('{8'h22}, 1, 0);
    chk(!got_ok && got_code == 2, "R2", got_code, 2);
    m_stuck_low = 0;
    @(posedge clk); #1 src_q.delete();

    // error flagged after first byte
    crc_at = 1;
    run_load('{8'hC3, 8'h99, 8'h42}, 3, 0);
    chk(!got_ok && got_code == 3, "R5", got_code, 3);
    chk(rx_bytes == 1 && src_q.size() == 2, "R5", src_q.size(), 2);
    repeat (20) @(negedge clk);
    chk(rx_bits == 8 && !cfg_clk, "R5", rx_bits, 8);
    crc_at = -1;
    @(posedge clk); #1 src_q.delete();

    // done never rises
    m_no_done = 1;
    run_load('{8'h5F}, 1, 0);
    chk(!got_ok && got_code == 4, "R7", got_code, 4);
    chk(tail_cnt > tail_need, "R7", tail_cnt, tail_need + 1);
    m_no_done = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule